// File: doc/BRIEF.md
# Home-Node Full-Map Directory Engine

This block is the coherence engine at the home node of a set of memory lines, shared by `NPROC` processors. Each line has one directory entry of `NPROC+1` bits: a dirty flag and one presence flag per processor. The engine takes one request at a time from some processor: a read miss, a write miss, a write hit on a line it holds clean, or an eviction. It reads the entry, sends the commands that the protocol needs, and writes the entry back with its new value.

Commands leave on a valid/ready stream. There are three kinds: a data reply, an invalidation, and a write-back request to the current owner. The stream obeys the usual rules. A command stays valid with all its fields unchanged until `cmd_ready` is seen high at a rising edge, and exactly one command moves per handshake. `cmd_valid` never depends on `cmd_ready`. Requests come in on their own valid/ready handshake. `req_ready` is high only while the engine is idle, so back-pressure holds a requester off until the previous transaction has fully retired. After it sends a write-back request, the engine waits for a one-cycle `wb_done` pulse, which marks the owner's data landing in home memory. Only then does it reply.

Top module: `dir_home_engine`

## Requirements
- R1: Processor p owns presence flag p+1 of an entry and flag 0 is the dirty flag. Out of reset every entry is zero, `req_ready` is 1 and `cmd_valid` is 0.
- R2: A read miss (`req_op`=0) on a clean or uncached line sends exactly one data command (`cmd_kind`=0) to the requester and adds it as a sharer.
- R3: A read miss on a dirty line sends a write-back request (`cmd_kind`=2) to the owner, waits for `wb_done`, then sends data to the requester. The line ends clean, shared by the old owner and the requester.
- R4: A write miss (`req_op`=1) on an uncached line sends data to the requester, and the line becomes dirty with the requester as its only holder.
- R5: A write miss on a clean shared line sends one invalidation (`cmd_kind`=1) to each sharer, lowest processor number first. Data to the requester follows, and the line ends dirty at the requester alone.
- R6: A write miss on a dirty line sends a write-back request to the owner, waits for `wb_done`, then sends data. The old owner is removed and the line ends dirty at the requester alone.
- R7: A write hit on a clean line (`req_op`=2) invalidates every other sharer, lowest first, and sends no data. The line ends dirty at the requester alone.
- R8: Eviction (`req_op`=3) of a dirty line clears the whole entry. Eviction of a clean line clears only the evicting processor's flag. Neither sends a command.
- R9: From the cycle a request is taken until its last command is sent, `req_ready` stays low and no other request is taken.
- R10: While `cmd_valid` is high and `cmd_ready` is low, the command's kind, destination and line hold steady, and each handshake moves exactly one command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and can take a request |
| req_op | input | 2 | 0 read miss, 1 write miss, 2 write hit on clean, 3 eviction |
| req_proc | input | $clog2(NPROC) | Requesting processor |
| req_line | input | $clog2(NLINES) | Line index |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Receiver takes the command |
| cmd_kind | output | 2 | 0 data, 1 invalidate, 2 write-back request |
| cmd_dest | output | $clog2(NPROC) | Target processor |
| cmd_line | output | $clog2(NLINES) | Line the command refers to |
| wb_done | input | 1 | Pulse: owner's write-back has reached home memory |

## Verification
The hardest state to reach from the ports is a long invalidation fan-out or a write-back handover that is stalled by back-pressure in the middle of its sequence. Reaching it first requires building up many sharers or a dirty owner through legal earlier requests. A directed opening fills one line with every processor as a sharer, then moves ownership between processors. The random phase chooses only legal requests from a bench model of each entry and works on a few hot lines, so that sharing builds up. It drops `cmd_ready` on about a quarter of cycles and delays `wb_done` by a random number of cycles.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    OP_RD_MISS = 2'd0,
    OP_WR_MISS = 2'd1,
    OP_WR_HIT  = 2'd2,
    OP_EVICT   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    CMD_DATA  = 2'd0,
    CMD_INV   = 2'd1,
    CMD_WBREQ = 2'd2
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_INV, S_WBREQ, S_WBWAIT, S_DATA
  } state_e;
endpackage

// File: rtl/pick_low.sv
module pick_low #(
  parameter int W = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  bits,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (bits[k]) idx = IW'(k);
    end
    any = |bits;
  end
endmodule

// File: rtl/dir_table.sv
module dir_table #(
  parameter int NPROC  = 4,
  parameter int NLINES = 16,
  localparam int VW = NPROC + 1,
  localparam int LW = $clog2(NLINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rd_line,
  output logic [VW-1:0] rd_vec,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_line,
  input  logic [VW-1:0] wr_vec
);
  logic [VW-1:0] mem [NLINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NLINES; k++) mem[k] <= '0;
    end else if (wr_en) begin
      mem[wr_line] <= wr_vec;
    end
  end

  assign rd_vec = mem[rd_line];

  // R6: a dirty entry always names exactly one holder
  a_r6_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_vec[0]) |-> ($countones(wr_vec[VW-1:1]) == 1));
endmodule

// File: rtl/dir_plan.sv
module dir_plan
  import dir_pkg::*;
#(
  parameter int NPROC = 4,
  localparam int VW = NPROC + 1,
  localparam int PW = $clog2(NPROC)
) (
  input  logic [1:0]       op,
  input  logic [PW-1:0]    proc,
  input  logic [VW-1:0]    vec,
  output logic [NPROC-1:0] inv_mask,
  output logic             need_wb,
  output logic [PW-1:0]    owner,
  output logic             need_data,
  output logic [VW-1:0]    fin_vec
);
  logic [NPROC-1:0] pres, rbit;
  logic             dirty, any_pres;

  assign pres  = vec[VW-1:1];
  assign dirty = vec[0];
  assign rbit  = NPROC'(1) << proc;

  pick_low #(.W(NPROC)) u_owner (.bits(pres), .idx(owner), .any(any_pres));

  always_comb begin
    inv_mask  = '0;
    need_wb   = 1'b0;
    need_data = 1'b0;
    fin_vec   = vec;
    unique case (op_e'(op))
      OP_RD_MISS: begin
        need_wb   = dirty;
        need_data = 1'b1;
        fin_vec   = {pres | rbit, 1'b0};
      end
      OP_WR_MISS: begin
        need_wb   = dirty;
        inv_mask  = dirty ? '0 : (pres & ~rbit);
        need_data = 1'b1;
        fin_vec   = {rbit, 1'b1};
      end
      OP_WR_HIT: begin
        if (!dirty) begin
          inv_mask = pres & ~rbit;
          fin_vec  = {rbit, 1'b1};
        end
      end
      OP_EVICT: begin
        fin_vec = dirty ? '0 : {pres & ~rbit, 1'b0};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dir_home_engine.sv
module dir_home_engine
  import dir_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int NLINES = 16,
  localparam int VW = NPROC + 1,
  localparam int PW = $clog2(NPROC),
  localparam int LW = $clog2(NLINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [PW-1:0] req_proc,
  input  logic [LW-1:0] req_line,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_kind,
  output logic [PW-1:0] cmd_dest,
  output logic [LW-1:0] cmd_line,
  input  logic          wb_done
);
  state_e           state;
  logic [LW-1:0]    cur_line;
  logic [PW-1:0]    cur_proc, wb_dest, inv_dest;
  logic [NPROC-1:0] pend, pend_after;
  logic             data_pend, inv_any;
  logic [VW-1:0]    fin_hold;

  logic [VW-1:0]    rd_vec, wr_vec;
  logic [LW-1:0]    wr_line;
  logic             wr_en;

  logic [NPROC-1:0] p_inv;
  logic             p_wb, p_data;
  logic [PW-1:0]    p_owner;
  logic [VW-1:0]    p_fin;

  logic accept, fire, done_now, finish;

  dir_table #(.NPROC(NPROC), .NLINES(NLINES)) u_table (
    .clk(clk), .rst_n(rst_n), .rd_line(req_line), .rd_vec(rd_vec),
    .wr_en(wr_en), .wr_line(wr_line), .wr_vec(wr_vec)
  );

  dir_plan #(.NPROC(NPROC)) u_plan (
    .op(req_op), .proc(req_proc), .vec(rd_vec), .inv_mask(p_inv),
    .need_wb(p_wb), .owner(p_owner), .need_data(p_data), .fin_vec(p_fin)
  );

  pick_low #(.W(NPROC)) u_inv_pick (.bits(pend), .idx(inv_dest), .any(inv_any));

  assign req_ready  = (state == S_IDLE);
  assign accept     = req_valid && req_ready;
  assign cmd_valid  = (state == S_INV) || (state == S_WBREQ) || (state == S_DATA);
  assign fire       = cmd_valid && cmd_ready;
  assign pend_after = pend & ~(NPROC'(1) << inv_dest);
  assign done_now   = !(|p_inv) && !p_wb && !p_data;
  assign finish     = fire && ((state == S_DATA) ||
                               (state == S_INV && pend_after == '0 && !data_pend));

  assign wr_en   = (accept && done_now) || finish;
  assign wr_line = accept ? req_line : cur_line;
  assign wr_vec  = accept ? p_fin : fin_hold;

  always_comb begin
    cmd_kind = CMD_DATA;
    cmd_dest = cur_proc;
    unique case (state)
      S_INV:   begin cmd_kind = CMD_INV;   cmd_dest = inv_dest; end
      S_WBREQ: begin cmd_kind = CMD_WBREQ; cmd_dest = wb_dest;  end
      default: ;
    endcase
  end
  assign cmd_line = cur_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur_line  <= '0;
      cur_proc  <= '0;
      wb_dest   <= '0;
      pend      <= '0;
      data_pend <= 1'b0;
      fin_hold  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          cur_line  <= req_line;
          cur_proc  <= req_proc;
          wb_dest   <= p_owner;
          pend      <= p_inv;
          data_pend <= p_data;
          fin_hold  <= p_fin;
          if (|p_inv)      state <= S_INV;
          else if (p_wb)   state <= S_WBREQ;
          else if (p_data) state <= S_DATA;
        end
        S_INV: if (fire) begin
          pend <= pend_after;
          if (pend_after == '0) state <= data_pend ? S_DATA : S_IDLE;
        end
        S_WBREQ:  if (fire)    state <= S_WBWAIT;
        S_WBWAIT: if (wb_done) state <= S_DATA;
        S_DATA:   if (fire)    state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9: no request is taken while a command is outstanding
  a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);

  // R10: a stalled command holds its fields
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_kind) && $stable(cmd_dest) && $stable(cmd_line)));

  // R3: the reply waits for the write-back to land
  a_r3_wait_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WBWAIT && !wb_done) |=> (state == S_WBWAIT && !cmd_valid));

  // R5: the requester is never sent its own invalidation
  a_r5_no_self_inv: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INV) |-> (inv_any && !pend[cur_proc]));
endmodule

// File: tb/tb_dir_home_engine.sv
module tb_dir_home_engine;
  localparam int NP = 4;
  localparam int NL = 16;
  localparam int PW = $clog2(NP);
  localparam int LW = $clog2(NL);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [PW-1:0] req_proc = '0;
  logic [LW-1:0] req_line = '0;
  logic          cmd_valid;
  logic          cmd_ready = 1'b0;
  logic [1:0]    cmd_kind;
  logic [PW-1:0] cmd_dest;
  logic [LW-1:0] cmd_line;
  logic          wb_done = 1'b0;

  int compared = 0;
  int mismatched = 0;

  logic [NP:0] mvec [NL];
  int exp_kind [8];
  int exp_dest [8];
  int exp_n;

  always #4 clk = ~clk;

  dir_home_engine #(.NPROC(NP), .NLINES(NL)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_proc(req_proc), .req_line(req_line),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_dest(cmd_dest), .cmd_line(cmd_line), .wb_done(wb_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic string tag_of(input int op, input logic dirty, input int nsh);
    case (op)
      0: return dirty ? "R3" : "R2";
      1: return dirty ? "R6" : (nsh != 0 ? "R5" : "R4");
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic push(input int k, input int d);
    exp_kind[exp_n] = k;
    exp_dest[exp_n] = d;
    exp_n++;
  endtask

  // Expected command list and new entry, straight from the requirements
  task automatic plan_expect(input int op, input int p, input int l);
    logic [NP:0]   v;
    logic [NP-1:0] pres, rb;
    int owner;
    v = mvec[l];
    pres = v[NP:1];
    rb = NP'(1) << p;
    owner = 0;
    for (int k = NP - 1; k >= 0; k--) if (pres[k]) owner = k;
    exp_n = 0;
    case (op)
      0: begin
        if (v[0]) push(2, owner);
        push(0, p);
        mvec[l] = {pres | rb, 1'b0};
      end
      1: begin
        if (v[0]) push(2, owner);
        else for (int k = 0; k < NP; k++) if (pres[k] && k != p) push(1, k);
        push(0, p);
        mvec[l] = {rb, 1'b1};
      end
      2: begin
        if (!v[0]) begin
          for (int k = 0; k < NP; k++) if (pres[k] && k != p) push(1, k);
          mvec[l] = {rb, 1'b1};
        end
      end
      default: mvec[l] = v[0] ? '0 : {pres & ~rb, 1'b0};
    endcase
  endtask

  task automatic run_req(input int op, input int p, input int l);
    string tg;
    int got, guard, wb_cnt;
    bit wb_arm, busy_checked;
    tg = tag_of(op, mvec[l][0], $countones(mvec[l][NP:1] & ~(NP'(1) << p)));
    plan_expect(op, p, l);
    @(negedge clk);
    guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    req_valid = 1'b1;
    req_op = 2'(op);
    req_proc = PW'(p);
    req_line = LW'(l);
    @(negedge clk);
    req_valid = 1'b0;
    got = 0; guard = 0; wb_arm = 0; wb_cnt = 0; busy_checked = 0;
    while (got < exp_n && guard < 300) begin
      if (!busy_checked) begin
        check(req_ready == 1'b0, "R9 busy", int'(req_ready), 0);
        busy_checked = 1;
      end
      wb_done = 1'b0;
      if (wb_arm) begin
        if (wb_cnt == 0) begin wb_done = 1'b1; wb_arm = 0; end
        else wb_cnt--;
      end
      cmd_ready = ($urandom % 4) != 0;
      if (cmd_valid && cmd_ready) begin
        check(int'(cmd_kind) == exp_kind[got] && int'(cmd_dest) == exp_dest[got]
              && int'(cmd_line) == l, tg,
              int'(cmd_kind) * 100 + int'(cmd_dest) * 10 + int'(cmd_line != LW'(l)),
              exp_kind[got] * 100 + exp_dest[got] * 10);
        if (exp_kind[got] == 2) begin wb_arm = 1; wb_cnt = 1 + $urandom % 3; end
        got++;
      end
      @(negedge clk);
      guard++;
    end
    wb_done = 1'b0;
    cmd_ready = 1'b0;
    if (got < exp_n) check(0, {tg, " missing command"}, got, exp_n);
    check(req_ready == 1'b1 && cmd_valid == 1'b0, "R10 no extra command",
          int'(cmd_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < NL; k++) mvec[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && cmd_valid == 1'b0, "R1 reset", int'(cmd_valid), 0);

    // Directed: fill line 5 with every sharer, then move ownership around
    for (int p = 0; p < NP; p++) run_req(0, p, 5);   // R2
    run_req(2, 2, 5);                                // R7: inv 0,1,3
    run_req(0, 0, 5);                                // R3
    run_req(1, 1, 5);                                // R5: inv 0,2
    run_req(1, 3, 5);                                // R6
    run_req(3, 3, 5);                                // R8 dirty evict
    run_req(1, 0, 5);                                // R4 after clear
    run_req(3, 0, 5);                                // R8
    run_req(0, 2, 7); run_req(0, 1, 7);
    run_req(3, 2, 7);                                // R8 clean evict
    run_req(1, 3, 7);                                // R5: inv 1 only

    // Random legal traffic on a few hot lines
    for (int n = 0; n < 400; n++) begin
      int l, p, op;
      l = ($urandom % 8 == 0) ? int'($urandom % NL) : int'($urandom % 3);
      p = $urandom % NP;
      if (mvec[l][p + 1]) op = mvec[l][0] ? 3 : (($urandom % 2) ? 2 : 3);
      else op = ($urandom % 2) ? 0 : 1;
      run_req(op, p, l);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule